// File: doc/BRIEF.md
# Pipelined Triple-DES Block Cipher (ECB)

This core encrypts or decrypts 64-bit blocks with Triple DES in electronic codebook mode. Each block is put through three DES passes under its own set of three keys. Every round of every pass is one register stage, so the pipeline has 48 stages. One block can enter on every clock. The result leaves after a fixed latency, with a valid flag that travels beside the data.

Each block carries its key bundle and a direction bit down the pipe. The round subkeys are computed at each stage from that block's own keys. Passes that run in the decrypt direction take their subkeys from a right-rotating schedule. Because of this, keys and direction may change from one clock to the next without a stall. The S-boxes, expansion and permutations follow the public DES standard. Bit 63 of every 64-bit bus is the first DES bit.

Top module: `tdes_ecb_pipe`

## Requirements
- R1: With `in_mode` = 0 the core returns E_K3(D_K2(E_K1(P))). When all three keys are equal, this is single DES, for example:
  - key 133457799BBCDFF1 with block 0123456789ABCDEF gives 85E813540F0AB405;
  - key 0E329232EA6D0D73 with block 8787878787878787 gives 0000000000000000.
- R2: With `in_mode` = 1 the core returns D_K1(E_K2(D_K3(C))). Under the same keys this exactly inverts R1.
- R3: The key bundle is split as follows: K1 is `in_keys[191:128]`, K2 is `in_keys[127:64]` and K3 is `in_keys[63:0]`. When two adjacent passes share a key they cancel, leaving single DES under the remaining key.
- R4: The lowest bit of every key byte (the parity bit) has no effect on the result.
- R5: `out_valid` rises exactly 48 clocks after the matching `in_valid` sample. Blocks leave in the order they entered.
- R6: Every block uses only its own keys and mode (ECB). Identical inputs give identical outputs, whatever surrounds them in the stream.
- R7: Blocks presented on consecutive clocks, with keys and mode changing on every clock, come out on consecutive clocks with no stall.
- R8: While reset is asserted, and whenever `in_valid` is low, nothing is accepted. `out_valid` stays low and no result is produced for such cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A block is presented this cycle |
| in_mode | input | 1 | 0 = encrypt (EDE), 1 = decrypt (DED) |
| in_keys | input | 192 | Key bundle: K1 in the high third, K3 in the low third |
| in_block | input | 64 | Plaintext or ciphertext block |
| out_valid | output | 1 | Result present this cycle |
| out_block | output | 64 | Result block |

## Verification
The assertions assume that a block's keys and mode are sampled together with it. They also assume that the wrap-around check on the key schedule sees a complete bundle on every valid stage. The stimulus therefore changes keys and mode only together with `in_valid`, and drives random values on the data and key buses whenever `in_valid` is low or reset is held. Random blocks and keys from a fixed seed are run through the encrypt-then-decrypt round trip. Directed known-answer cases, cases with shared keys and cases with flipped parity bits are mixed into the same stream.

// File: rtl/tdes_pkg.sv
package tdes_pkg;

  localparam int BLK_W    = 64;
  localparam int HALF_W   = BLK_W / 2;
  localparam int KEY_W    = 64;
  localparam int NKEYS    = 3;
  localparam int BUNDLE_W = KEY_W * NKEYS;
  localparam int CD_W     = 28;
  localparam int SUBK_W   = 48;
  localparam int ROUNDS   = 16;
  localparam int PASSES   = 3;
  localparam int STAGES   = ROUNDS * PASSES;
  localparam int CNT_W    = $clog2(STAGES + 1);

  // Selection table for the 56 key bits that enter the schedule
  localparam int unsigned PC1_T [0:55] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

  // Compression from the 56-bit schedule state to the 48-bit subkey
  localparam int unsigned PC2_T [0:47] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  // Permutation applied after the substitution layer
  localparam int unsigned P_T [0:31] = '{
    16,  7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
     2,  8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25};

  // Eight substitution boxes, 4 rows x 16 nibbles each, row 0 in the top bits
  localparam logic [255:0] SBOX_T [0:7] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B};

  // Source position (1-based, first bit = MSB) of initial-permutation output o
  function automatic int ip_src(int o);
    int rr;
    int cc;
    rr = o / 8;
    cc = o % 8;
    return ((rr < 4) ? (58 + 2 * rr) : (57 + 2 * (rr - 4))) - 8 * cc;
  endfunction

  function automatic logic [BLK_W-1:0] perm_in(logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    y = '0;
    for (int o = 0; o < BLK_W; o++) y[BLK_W-1-o] = x[BLK_W-ip_src(o)];
    return y;
  endfunction

  function automatic logic [BLK_W-1:0] perm_out(logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    y = '0;
    for (int o = 0; o < BLK_W; o++) y[BLK_W-ip_src(o)] = x[BLK_W-1-o];
    return y;
  endfunction

  function automatic logic [SUBK_W-1:0] expand(logic [HALF_W-1:0] r);
    logic [SUBK_W-1:0] y;
    int src;
    y = '0;
    for (int o = 0; o < SUBK_W; o++) begin
      src = ((4 * (o / 6) + (o % 6) + HALF_W - 1) % HALF_W) + 1;
      y[SUBK_W-1-o] = r[HALF_W-src];
    end
    return y;
  endfunction

  function automatic logic [3:0] sbox(int idx, logic [5:0] b);
    int n;
    n = 16 * int'({b[5], b[0]}) + int'(b[4:1]);
    return SBOX_T[idx][255-4*n -: 4];
  endfunction

  function automatic logic [HALF_W-1:0] feistel(logic [HALF_W-1:0] r,
                                                logic [SUBK_W-1:0] k);
    logic [SUBK_W-1:0] x;
    logic [HALF_W-1:0] s;
    logic [HALF_W-1:0] y;
    x = expand(r) ^ k;
    s = '0;
    for (int i = 0; i < 8; i++) s[HALF_W-1-4*i -: 4] = sbox(i, x[SUBK_W-1-6*i -: 6]);
    y = '0;
    for (int o = 0; o < HALF_W; o++) y[HALF_W-1-o] = s[HALF_W-P_T[o]];
    return y;
  endfunction

  function automatic logic [2*CD_W-1:0] key_select(logic [KEY_W-1:0] k);
    logic [2*CD_W-1:0] y;
    y = '0;
    for (int o = 0; o < 2 * CD_W; o++) y[2*CD_W-1-o] = k[KEY_W-PC1_T[o]];
    return y;
  endfunction

  function automatic logic [SUBK_W-1:0] key_compress(logic [2*CD_W-1:0] cd);
    logic [SUBK_W-1:0] y;
    y = '0;
    for (int o = 0; o < SUBK_W; o++) y[SUBK_W-1-o] = cd[2*CD_W-PC2_T[o]];
    return y;
  endfunction

  function automatic logic [CD_W-1:0] rot_left(logic [CD_W-1:0] x, int n);
    return (x << n) | (x >> (CD_W - n));
  endfunction

  function automatic logic [CD_W-1:0] rot_right(logic [CD_W-1:0] x, int n);
    return (x >> n) | (x << (CD_W - n));
  endfunction

  // Key used by pass p: forward order K1,K2,K3 when encrypting, reversed otherwise
  function automatic logic [KEY_W-1:0] pass_key(logic [BUNDLE_W-1:0] bundle,
                                                logic mode, int p);
    int idx;
    idx = mode ? (PASSES - 1 - p) : p;
    return bundle[BUNDLE_W-1-KEY_W*idx -: KEY_W];
  endfunction

endpackage

// File: rtl/tdes_rst_sync.sv
module tdes_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_n;

  always_comb sync_n = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_n;
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/tdes_round_stage.sv
module tdes_round_stage
  import tdes_pkg::*;
#(
  parameter int STAGE = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                v_in,
  input  logic                mode_in,
  input  logic [BUNDLE_W-1:0] keys_in,
  input  logic [HALF_W-1:0]   l_in,
  input  logic [HALF_W-1:0]   r_in,
  input  logic [CD_W-1:0]     c_in,
  input  logic [CD_W-1:0]     d_in,
  output logic                v_q,
  output logic                mode_q,
  output logic [BUNDLE_W-1:0] keys_q,
  output logic [HALF_W-1:0]   l_q,
  output logic [HALF_W-1:0]   r_q,
  output logic [CD_W-1:0]     c_q,
  output logic [CD_W-1:0]     d_q
);

  localparam int PASS     = STAGE / ROUNDS;
  localparam int ROUND    = STAGE % ROUNDS;
  localparam bit FIRST_RD = (ROUND == 0);
  localparam bit LAST_RD  = (ROUND == ROUNDS - 1);
  localparam bit MID_PASS = (PASS == 1);
  localparam bit ONE_STEP = (ROUND == 0) || (ROUND == 1) || (ROUND == 8) || (ROUND == 15);
  localparam int SHL      = ONE_STEP ? 1 : 2;
  localparam int SHR      = FIRST_RD ? 0 : (ONE_STEP ? 1 : 2);

  logic                dec_pass;
  logic [KEY_W-1:0]    key_pass;
  logic [2*CD_W-1:0]   cd_base;
  logic [CD_W-1:0]     c_n;
  logic [CD_W-1:0]     d_n;
  logic [SUBK_W-1:0]   subkey;
  logic [HALF_W-1:0]   f_out;
  logic [HALF_W-1:0]   l_n;
  logic [HALF_W-1:0]   r_n;

  // Next-state: key schedule step and one Feistel round
  always_comb begin
    dec_pass = mode_in ^ MID_PASS;
    key_pass = pass_key(keys_in, mode_in, PASS);
    cd_base  = FIRST_RD ? key_select(key_pass) : {c_in, d_in};
    if (dec_pass) begin
      c_n = rot_right(cd_base[2*CD_W-1:CD_W], SHR);
      d_n = rot_right(cd_base[CD_W-1:0], SHR);
    end else begin
      c_n = rot_left(cd_base[2*CD_W-1:CD_W], SHL);
      d_n = rot_left(cd_base[CD_W-1:0], SHL);
    end
    subkey = key_compress({c_n, d_n});
    f_out  = feistel(r_in, subkey);
    if (LAST_RD) begin
      l_n = l_in ^ f_out;
      r_n = r_in;
    end else begin
      l_n = r_in;
      r_n = l_in ^ f_out;
    end
  end

  // Valid bit: reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_in;
  end

  // Datapath: no reset, loaded only with a valid block
  always_ff @(posedge clk) begin
    if (v_in) begin
      mode_q <= mode_in;
      keys_q <= keys_in;
      l_q    <= l_n;
      r_q    <= r_n;
      c_q    <= c_n;
      d_q    <= d_n;
    end
  end

  // After 16 rounds the schedule has turned a full 28 positions when encrypting,
  // and 27 right (one left) when decrypting; cross-check against the key itself.
  generate
    if (LAST_RD) begin : g_wrap_chk
      logic [2*CD_W-1:0] cd_ref;
      logic              dec_q;
      always_comb begin
        cd_ref = key_select(pass_key(keys_q, mode_q, PASS));
        dec_q  = mode_q ^ MID_PASS;
      end
      a_r1_enc_sched_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && !dec_q) |-> ({c_q, d_q} == cd_ref));
      a_r2_dec_sched_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && dec_q) |-> ({c_q, d_q} == {rot_left(cd_ref[2*CD_W-1:CD_W], 1),
                                            rot_left(cd_ref[CD_W-1:0], 1)}));
    end
  endgenerate

endmodule

// File: rtl/tdes_ecb_pipe.sv
module tdes_ecb_pipe
  import tdes_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_mode,
  input  logic [BUNDLE_W-1:0] in_keys,
  input  logic [BLK_W-1:0]    in_block,
  output logic                out_valid,
  output logic [BLK_W-1:0]    out_block
);

  logic rst_sync_n;

  tdes_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic                v_w    [0:STAGES];
  logic                mode_w [0:STAGES];
  logic [BUNDLE_W-1:0] keys_w [0:STAGES];
  logic [HALF_W-1:0]   l_w    [0:STAGES];
  logic [HALF_W-1:0]   r_w    [0:STAGES];
  logic [CD_W-1:0]     c_w    [0:STAGES];
  logic [CD_W-1:0]     d_w    [0:STAGES];
  logic [BLK_W-1:0]    ip_blk;

  always_comb begin
    ip_blk    = perm_in(in_block);
    v_w[0]    = in_valid;
    mode_w[0] = in_mode;
    keys_w[0] = in_keys;
    l_w[0]    = ip_blk[BLK_W-1:HALF_W];
    r_w[0]    = ip_blk[HALF_W-1:0];
    c_w[0]    = '0;
    d_w[0]    = '0;
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      tdes_round_stage #(.STAGE(s)) u_stage (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .v_in    (v_w[s]),
        .mode_in (mode_w[s]),
        .keys_in (keys_w[s]),
        .l_in    (l_w[s]),
        .r_in    (r_w[s]),
        .c_in    (c_w[s]),
        .d_in    (d_w[s]),
        .v_q     (v_w[s+1]),
        .mode_q  (mode_w[s+1]),
        .keys_q  (keys_w[s+1]),
        .l_q     (l_w[s+1]),
        .r_q     (r_w[s+1]),
        .c_q     (c_w[s+1]),
        .d_q     (d_w[s+1])
      );
    end
  endgenerate

  assign out_valid = v_w[STAGES];
  assign out_block = perm_out({l_w[STAGES], r_w[STAGES]});

  logic unused_tail;
  assign unused_tail = ^{mode_w[STAGES], keys_w[STAGES], c_w[STAGES], d_w[STAGES]};

  // Checker state: cycles since reset release (saturating) and blocks in flight
  logic [CNT_W-1:0] since_q, since_n;
  logic [CNT_W-1:0] inflight_q, inflight_n;

  always_comb begin
    since_n    = (since_q == CNT_W'(STAGES)) ? since_q : since_q + 1'b1;
    inflight_n = inflight_q + CNT_W'(in_valid) - CNT_W'(out_valid);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      since_q    <= '0;
      inflight_q <= '0;
    end else begin
      since_q    <= since_n;
      inflight_q <= inflight_n;
    end
  end

  a_r5_no_early_result: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (since_q == CNT_W'(STAGES)));
  a_r5_inflight_bound: assert property (@(posedge clk) disable iff (!rst_sync_n)
    inflight_q <= CNT_W'(STAGES));
  a_r8_no_phantom_out: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (inflight_q != '0));

  always @(posedge clk) begin
    if (!rst_sync_n) a_r8_reset_quiet: assert (!out_valid);
  end

endmodule

// File: tb/tdes_ecb_pipe_tb.sv
module tdes_ecb_pipe_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_mode = 1'b0;
  logic [191:0] in_keys = '0;
  logic [63:0]  in_block = '0;
  logic         out_valid;
  logic [63:0]  out_block;

  tdes_ecb_pipe u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_keys   (in_keys),
    .in_block  (in_block),
    .out_valid (out_valid),
    .out_block (out_block)
  );

  always #10 clk = ~clk;

  localparam logic [63:0] KA  = 64'h133457799BBCDFF1;
  localparam logic [63:0] PA  = 64'h0123456789ABCDEF;
  localparam logic [63:0] CA  = 64'h85E813540F0AB405;
  localparam logic [63:0] KB  = 64'h0E329232EA6D0D73;
  localparam logic [63:0] PB  = 64'h8787878787878787;
  localparam logic [63:0] CB  = 64'h0000000000000000;
  localparam logic [63:0] PAR = 64'h0101010101010101;
  localparam int LAT  = 48;
  localparam int NRND = 40;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [63:0] exp_blk [0:255];
  bit          has_exp [0:255];
  string       exp_req [0:255];
  int          iss_cyc [0:255];
  logic [63:0] got_blk [0:255];
  int          got_cyc [0:255];
  int          n_iss = 0;
  int          n_got = 0;

  logic [63:0]  rp [0:NRND-1];
  logic [191:0] rk [0:NRND-1];
  logic [63:0]  rc [0:NRND-1];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid && n_got < 256) begin
      got_blk[n_got] = out_block;
      got_cyc[n_got] = cyc;
      n_got++;
    end
  end

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [191:0] bundle(logic [63:0] k1, logic [63:0] k2, logic [63:0] k3);
    return {k1, k2, k3};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(logic mode, logic [191:0] keys, logic [63:0] blk,
                      bit hx, logic [63:0] ex, string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_mode  = mode;
    in_keys  = keys;
    in_block = blk;
    exp_blk[n_iss] = ex;
    has_exp[n_iss] = hx;
    exp_req[n_iss] = req;
    iss_cyc[n_iss] = cyc;
    n_iss++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_mode  = $urandom_range(0, 1);
      in_keys  = {rnd64(), rnd64(), rnd64()};
      in_block = rnd64();
    end
  endtask

  task automatic drain_and_check(int first);
    idle(LAT + 4);
    chk(n_got == n_iss, "R8", "result count", 64'(n_got), 64'(n_iss));
    for (int i = first; i < n_iss && i < n_got; i++) begin
      if (has_exp[i]) chk(got_blk[i] == exp_blk[i], exp_req[i], $sformatf("block %0d", i),
                          got_blk[i], exp_blk[i]);
      chk(got_cyc[i] - iss_cyc[i] == LAT, "R5", $sformatf("latency of block %0d", i),
          64'(got_cyc[i] - iss_cyc[i]), 64'(LAT));
    end
  endtask

  initial begin
    int unsigned seed_set;
    int base;
    seed_set = $urandom(32'd20240917);

    // Reset; garbage with in_valid high must be ignored (R8)
    #1 rst_n = 1'b0;
    in_valid = 1'b1;
    in_keys  = {rnd64(), rnd64(), rnd64()};
    in_block = rnd64();
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R8", "out_valid during reset", 64'(out_valid), 64'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    idle(LAT + 6);
    chk(out_valid == 1'b0, "R8", "out_valid idle after reset", 64'(out_valid), 64'd0);
    chk(n_got == 0, "R8", "no results from reset-time inputs", 64'(n_got), 64'd0);

    // Directed cases, keys changing on every clock, a gap in the middle
    base = n_iss;
    push(1'b0, bundle(KA, KA, KA), PA, 1, CA, "R1");
    push(1'b0, bundle(KB, KB, KB), PB, 1, CB, "R1");
    push(1'b1, bundle(KA, KA, KA), CA, 1, PA, "R2");
    idle(3);
    push(1'b1, bundle(KB, KB, KB), CB, 1, PB, "R2");
    begin
      logic [63:0] kx;
      kx = rnd64();
      push(1'b0, bundle(kx, kx, KA), PA, 1, CA, "R3");
      kx = rnd64();
      push(1'b0, bundle(KB, kx, kx), PB, 1, CB, "R3");
      kx = rnd64();
      push(1'b1, bundle(KA, kx, kx), CA, 1, PA, "R3");
      kx = rnd64();
      push(1'b1, bundle(kx, kx, KB), CB, 1, PB, "R3");
    end
    push(1'b0, bundle(KA ^ PAR, KA, KA ^ PAR), PA, 1, CA, "R4");
    push(1'b1, bundle(KB ^ PAR, KB ^ PAR, KB), CB, 1, PB, "R4");
    drain_and_check(base);

    // Random encryption stream with random gaps; entry 10 repeats entry 3 (R6)
    base = n_iss;
    for (int j = 0; j < NRND; j++) begin
      if (j == 10) begin
        rp[j] = rp[3];
        rk[j] = rk[3];
      end else begin
        rp[j] = rnd64();
        rk[j] = {rnd64(), rnd64(), rnd64()};
      end
      push(1'b0, rk[j], rp[j], 0, '0, "R1");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    drain_and_check(base);
    for (int j = 0; j < NRND; j++) rc[j] = got_blk[base + j];
    chk(rc[10] == rc[3], "R6", "repeated block gives same result", rc[10], rc[3]);

    // Back-to-back mixed directions: decrypt each result, re-encrypt each plaintext
    base = n_iss;
    for (int j = 0; j < NRND; j++) begin
      push(1'b1, rk[j], rc[j], 1, rp[j], "R2");
      push(1'b0, rk[j], rp[j], 1, rc[j], "R6");
    end
    drain_and_check(base);
    begin
      int gaps;
      gaps = 0;
      for (int i = base + 1; i < n_got; i++) if (got_cyc[i] != got_cyc[i-1] + 1) gaps++;
      chk(gaps == 0, "R7", "results on consecutive clocks", 64'(gaps), 64'd0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule